// File: doc/BRIEF.md
# MDIO Management Master with Background PHY Scanner

This block is a register-mapped management controller for a two-wire MDIO bus. Software reads and writes PHY registers through one user-access register. It sets a start flag together with the PHY address, the register index and, for a write, the data. It then polls until the flag drops. For a read, an acknowledge flag reports whether a PHY answered, and the read value is returned in the same register.

When no software request is waiting, a scanner reads the basic status register (index 1) of every PHY address in turn. For each address it records two things in 32-bit bitmaps: whether the PHY answered, and the PHY's link-status bit. A control register holds an enable bit, a read-only idle flag and the clock divider that sets the MDC rate. Each frame is 64 MDC cycles: a preamble of 32 ones, then a 32-bit clause-22 frame.

The register port is a plain word-indexed port. Writes take effect on a clock edge and reads are combinational. The bus side has an MDC output, plus an MDIO output, output-enable and input, for an external tri-state pad.

Top module: `mdio_scan_master`

## Requirements
- R1: After reset the word registers read as follows: control (word 0) reads 0x8000_0000 with the reset divider in bits 15:0; the alive bitmap (word 1), link bitmap (word 2) and user-access register (word 3) read 0; MDC and the output enable are low.
- R2: Within a frame, MDC has a period of divider+1 clocks, and a divider of 0 behaves as 1. The divider sits in control bits 15:0 and is captured when a frame begins. MDC is low whenever no frame is in progress.
- R3: Every frame drives 32 ones and then start bits 01. Next come the opcode (10 for read, 01 for write), the 5-bit PHY address, the 5-bit register index, two turnaround bits (10 on writes) and 16 data bits, MSB first. MDIO changes while MDC is low and is sampled on the rising edge. On reads the output enable is low from the first turnaround bit to the end of the frame.
- R4: Writing word 3 with bit 31 (GO) set starts an access. Bit 30 selects write (1) or read (0), bits 25:21 give the register index, bits 20:16 the PHY address and bits 15:0 the data. GO reads 1 until the frame ends and then clears. A read that a PHY answered sets bit 29 (ACK) and returns the data in bits 15:0.
- R5: A read that no PHY answers, where the second turnaround bit samples 1, completes with ACK = 0.
- R6: A user write delivers its 16 data bits to the PHY and completes with ACK = 0.
- R7: A write to word 3 while GO is 1 is ignored, and the pending request's fields are kept.
- R8: With enable set, the scanner reads register 1 of PHY addresses in ascending order, wrapping from 31 to 0. It sets or clears alive bit n from whether PHY n answered.
- R9: Link bitmap bit n holds bit 2 of the status value that PHY n last returned to the scanner, and is 0 when PHY n did not answer.
- R10: A pending user request takes the bus at the next frame boundary, ahead of the scanner. It completes within two frame lengths of being written.
- R11: Clearing enable (control bit 30) lets a frame already in progress finish, then sets the idle flag (bit 31) and starts no further frame, user or scan. A user request written while disabled stays pending. Setting enable again resumes operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 2 | Word index: 0 control, 1 alive, 2 link, 3 user access |
| regWr | input | 1 | Write strobe for the addressed word |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data of the addressed word (combinational) |
| mdc | output | 1 | Management clock to the PHYs |
| mdioOut | output | 1 | MDIO value driven by the controller |
| mdioOe | output | 1 | MDIO output enable |
| mdioIn | input | 1 | MDIO value seen on the pad |

## Verification
Two functions can land in the same cycle. A software write of GO can arrive on the same edge on which a scanner frame starts or ends. A rewrite of the user-access register can also coincide with the pending request still being outstanding. The bench issues user requests at arbitrary points while the scanner is running. It judges the outcome in two ways: it measures each request's completion latency against the two-frame bound, and it checks the returned fields and data against a behavioural PHY model. It also overwrites the user-access register right after setting GO, and checks that the original request is the one that is carried out.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int PHY_AW     = 5;
  localparam int NPHY       = 1 << PHY_AW;
  localparam int DATA_W     = 16;
  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = 64;
  localparam int BIT_CW     = 7;
  localparam int TA1_IDX    = PRE_BITS + 14;
  localparam int TA2_IDX    = TA1_IDX + 1;
  localparam int DATA_IDX   = TA2_IDX + 1;

  localparam logic [1:0] OFS_CTRL  = 2'd0;
  localparam logic [1:0] OFS_ALIVE = 2'd1;
  localparam logic [1:0] OFS_LINK  = 2'd2;
  localparam logic [1:0] OFS_USER  = 2'd3;

  // strobes from the control side to the frame datapath
  typedef struct packed {
    logic              start;
    logic              isRead;
    logic [PHY_AW-1:0] phyAddr;
    logic [PHY_AW-1:0] regIdx;
    logic [DATA_W-1:0] wdata;
  } mdioCmd_t;

  // status from the datapath back to control
  typedef struct packed {
    logic              busy;
    logic              done;
    logic              ack;
    logic [DATA_W-1:0] rdata;
  } mdioStat_t;

  function automatic logic [FRAME_BITS-1:0] buildFrame(input mdioCmd_t c);
    logic [1:0] op;
    logic [1:0] ta;
    logic [DATA_W-1:0] d;
    op = c.isRead ? 2'b10 : 2'b01;
    ta = c.isRead ? 2'b11 : 2'b10;
    d  = c.isRead ? {DATA_W{1'b1}} : c.wdata;
    return {{PRE_BITS{1'b1}}, 2'b01, op, c.phyAddr, c.regIdx, ta, d};
  endfunction

endpackage

// File: rtl/mdio_frame_dp.sv
module mdio_frame_dp
  import mdio_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divIn,
  input  mdioCmd_t         cmd,
  output mdioStat_t        stat,
  output logic             mdc,
  output logic             mdioOut,
  output logic             mdioOe,
  input  logic             mdioIn
);

  logic [DIV_W-1:0]      effDiv;
  logic [DIV_W-1:0]      halfNext;
  logic [DIV_W-1:0]      divQ;
  logic [DIV_W-1:0]      halfQ;
  logic [DIV_W-1:0]      cnt;
  logic                  busy;
  logic                  done;
  logic                  ack;
  logic                  isReadQ;
  logic [BIT_CW-1:0]     bitIdx;
  logic [BIT_CW-1:0]     nextIdx;
  logic [FRAME_BITS-1:0] shiftQ;
  logic [DATA_W-1:0]     rdata;
  logic                  riseNow;
  logic                  bitEnd;
  logic                  lastBit;

  // a divider of zero would give no high phase; run it as one
  assign effDiv   = (divIn == '0) ? DIV_W'(1) : divIn;
  assign halfNext = (effDiv >> 1) + {{(DIV_W-1){1'b0}}, effDiv[0]};

  assign riseNow = busy && (cnt == halfQ - DIV_W'(1));
  assign bitEnd  = busy && (cnt == divQ);
  assign lastBit = (bitIdx == BIT_CW'(FRAME_BITS - 1));
  assign nextIdx = bitIdx + BIT_CW'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      ack     <= 1'b0;
      isReadQ <= 1'b0;
      divQ    <= DIV_W'(1);
      halfQ   <= DIV_W'(1);
      cnt     <= '0;
      bitIdx  <= '0;
      shiftQ  <= '0;
      rdata   <= '0;
      mdc     <= 1'b0;
      mdioOut <= 1'b1;
      mdioOe  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (cmd.start) begin
          busy    <= 1'b1;
          divQ    <= effDiv;
          halfQ   <= halfNext;
          cnt     <= '0;
          bitIdx  <= '0;
          shiftQ  <= buildFrame(cmd);
          mdioOut <= 1'b1;
          mdioOe  <= 1'b1;
          isReadQ <= cmd.isRead;
          ack     <= 1'b0;
          rdata   <= '0;
          mdc     <= 1'b0;
        end
      end else begin
        cnt <= cnt + DIV_W'(1);
        if (riseNow) begin
          mdc <= 1'b1;
          if (isReadQ) begin
            if (bitIdx == BIT_CW'(TA2_IDX)) ack <= ~mdioIn;
            if (bitIdx >= BIT_CW'(DATA_IDX)) rdata <= {rdata[DATA_W-2:0], mdioIn};
          end
        end
        if (bitEnd) begin
          mdc <= 1'b0;
          cnt <= '0;
          if (lastBit) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            mdioOe  <= 1'b0;
            mdioOut <= 1'b1;
          end else begin
            bitIdx  <= nextIdx;
            shiftQ  <= shiftQ << 1;
            mdioOut <= shiftQ[FRAME_BITS-2];
            mdioOe  <= !(isReadQ && (nextIdx >= BIT_CW'(TA1_IDX)));
          end
        end
      end
    end
  end

  assign stat = '{busy: busy, done: done, ack: ack, rdata: rdata};

  AST_MDC_LOW_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdc); // R2

  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && isReadQ && bitIdx >= BIT_CW'(TA1_IDX)) |-> !mdioOe); // R3

  AST_PREAMBLE_ONES: assert property (@(posedge clk) disable iff (!rstN)
    (busy && bitIdx < BIT_CW'(PRE_BITS)) |-> (mdioOut && mdioOe)); // R3

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(busy) && !busy)); // R4

endmodule

// File: rtl/mdio_scan_ctrl.sv
module mdio_scan_ctrl
  import mdio_pkg::*;
#(
  parameter int              DIV_W     = 16,
  parameter logic [DIV_W-1:0] DIV_RESET = 16'd10,
  parameter int              SCAN_REG  = 1,
  parameter int              LINK_BIT  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       regAddr,
  input  logic             regWr,
  input  logic [31:0]      regWdata,
  output logic [31:0]      regRdata,
  input  mdioStat_t        stat,
  output mdioCmd_t         cmd,
  output logic [DIV_W-1:0] divOut
);

  localparam int PAD_W = 30 - DIV_W;

  logic              enable;
  logic [DIV_W-1:0]  divQ;
  logic [NPHY-1:0]   alive;
  logic [NPHY-1:0]   link;
  logic              userGo;
  logic              userWrite;
  logic              userAck;
  logic [PHY_AW-1:0] userReg;
  logic [PHY_AW-1:0] userPhy;
  logic [DATA_W-1:0] userData;
  logic [PHY_AW-1:0] scanAddr;
  logic              inFlight;
  logic              userOwn;
  logic              startUser;
  logic              startScan;
  logic              unusedWr;

  assign unusedWr = ^{regWdata[29:DIV_W], regWdata[28:26]};

  // user request wins at every frame boundary
  assign startUser = enable && !inFlight && userGo;
  assign startScan = enable && !inFlight && !userGo;

  always_comb begin
    cmd.start   = startUser || startScan;
    cmd.isRead  = startUser ? !userWrite : 1'b1;
    cmd.phyAddr = startUser ? userPhy : scanAddr;
    cmd.regIdx  = startUser ? userReg : PHY_AW'(SCAN_REG);
    cmd.wdata   = userData;
  end

  assign divOut = divQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable    <= 1'b0;
      divQ      <= DIV_RESET;
      alive     <= '0;
      link      <= '0;
      userGo    <= 1'b0;
      userWrite <= 1'b0;
      userAck   <= 1'b0;
      userReg   <= '0;
      userPhy   <= '0;
      userData  <= '0;
      scanAddr  <= '0;
      inFlight  <= 1'b0;
      userOwn   <= 1'b0;
    end else begin
      if (cmd.start) begin
        inFlight <= 1'b1;
        userOwn  <= startUser;
      end
      if (stat.done && inFlight) begin
        inFlight <= 1'b0;
        if (userOwn) begin
          userGo  <= 1'b0;
          userAck <= !userWrite && stat.ack;
          if (!userWrite) userData <= stat.rdata;
        end else begin
          alive[scanAddr] <= stat.ack;
          link[scanAddr]  <= stat.ack && stat.rdata[LINK_BIT];
          scanAddr        <= scanAddr + PHY_AW'(1);
        end
      end
      if (regWr) begin
        case (regAddr)
          OFS_CTRL: begin
            enable <= regWdata[30];
            divQ   <= regWdata[DIV_W-1:0];
          end
          OFS_USER: begin
            if (!userGo) begin
              userGo    <= regWdata[31];
              userWrite <= regWdata[30];
              userAck   <= 1'b0;
              userReg   <= regWdata[25:21];
              userPhy   <= regWdata[20:16];
              userData  <= regWdata[15:0];
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (regAddr)
      OFS_CTRL:  regRdata = {!inFlight, enable, {PAD_W{1'b0}}, divQ};
      OFS_ALIVE: regRdata = alive;
      OFS_LINK:  regRdata = link;
      default:   regRdata = {userGo, userWrite, userAck, 3'b000, userReg, userPhy, userData};
    endcase
  end

  AST_GO_CLEAR_ON_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(userGo) |-> $past(stat.done && userOwn)); // R4

  AST_USER_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (userGo && $past(userGo)) |-> $stable({userWrite, userReg, userPhy})); // R7

  AST_DISABLED_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !inFlight) |=> !inFlight); // R11

  AST_SCAN_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (stat.done && inFlight && !userOwn) |=> (scanAddr == PHY_AW'($past(scanAddr) + 1))); // R8

  AST_USER_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (!inFlight && enable && userGo) |=> (userOwn && inFlight)); // R10

endmodule

// File: rtl/mdio_scan_master.sv
module mdio_scan_master
  import mdio_pkg::*;
#(
  parameter int               DIV_W     = 16,
  parameter logic [DIV_W-1:0] DIV_RESET = 16'd10,
  parameter int               SCAN_REG  = 1,
  parameter int               LINK_BIT  = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  regAddr,
  input  logic        regWr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);

  mdioCmd_t         cmd;
  mdioStat_t        stat;
  logic [DIV_W-1:0] divSel;

  mdio_scan_ctrl #(
    .DIV_W    (DIV_W),
    .DIV_RESET(DIV_RESET),
    .SCAN_REG (SCAN_REG),
    .LINK_BIT (LINK_BIT)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .regWr   (regWr),
    .regWdata(regWdata),
    .regRdata(regRdata),
    .stat    (stat),
    .cmd     (cmd),
    .divOut  (divSel)
  );

  mdio_frame_dp #(
    .DIV_W(DIV_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .divIn  (divSel),
    .cmd    (cmd),
    .stat   (stat),
    .mdc    (mdc),
    .mdioOut(mdioOut),
    .mdioOe (mdioOe),
    .mdioIn (mdioIn)
  );

endmodule

// File: tb/mdio_scan_master_bench.sv
module mdio_scan_master_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic        regWr = 1'b0;
  logic [31:0] regWdata = 32'd0;
  logic [31:0] regRdata;
  logic        mdc, mdioOut, mdioOe, mdioIn;

  always #5 clk = ~clk;

  mdio_scan_master u_mdio_scan_master (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .regWdata(regWdata), .regRdata(regRdata), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  // ---------------- behavioural PHY population ----------------
  logic [31:0] present, linkMask;
  logic [15:0] mem [0:31][0:31];
  logic drv = 1'b0, drvVal = 1'b1;
  assign mdioIn = drv ? drvVal : 1'b1;

  int pState = 0, ones = 0, hcnt = 0, tcnt = 0, dcnt = 0;
  int frames = 0, orderErr = 0, contention = 0, mdcRises = 0;
  logic [11:0] hdr;
  logic [15:0] wsh;
  logic [4:0]  curPhy, curReg, prevScan = 5'd31;
  logic opR, answer;
  longint cyc = 0;
  always @(posedge clk) cyc++;

  always @(posedge mdc) begin
    logic ln;
    ln = mdioOe ? mdioOut : mdioIn;
    mdcRises++;
    if (mdioOe && drv) contention++;
    case (pState)
      0: if (ln) ones++; else begin if (ones >= 32) pState = 1; ones = 0; end
      1: if (ln) begin pState = 2; hcnt = 0; end else pState = 0;
      2: begin
        hdr = {hdr[10:0], ln}; hcnt++;
        if (hcnt == 12) begin
          opR = (hdr[11:10] == 2'b10); curPhy = hdr[9:5]; curReg = hdr[4:0];
          frames++;
          if (opR && curReg == 5'd1) begin
            if (curPhy != 5'(prevScan + 1)) orderErr++;
            prevScan = curPhy;
          end
          answer = opR && present[curPhy];
          pState = 3; tcnt = 0;
        end
      end
      3: begin
        tcnt++;
        if (tcnt == 1 && answer) begin drv = 1'b1; drvVal = 1'b0; end
        if (tcnt == 2) begin
          if (answer) drvVal = mem[curPhy][curReg][15];
          pState = 4; dcnt = 0;
        end
      end
      default: begin
        dcnt++; wsh = {wsh[14:0], ln};
        if (dcnt < 16) begin
          if (answer) drvVal = mem[curPhy][curReg][15-dcnt];
        end else begin
          drv = 1'b0;
          if (!opR && present[curPhy]) mem[curPhy][curReg] = wsh;
          pState = 0; ones = 0;
        end
      end
    endcase
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] d);
    regAddr = a; #1 d = regRdata;
  endtask

  function automatic logic [31:0] ctrlWord(input bit en, input logic [15:0] dv);
    return {1'b0, en, 14'd0, dv};
  endfunction

  function automatic logic [31:0] userWord(input bit wr, input logic [4:0] phy, input logic [4:0] ri, input logic [15:0] d);
    return {1'b1, wr, 1'b0, 3'b000, ri, phy, d};
  endfunction

  task automatic waitGo(output logic [31:0] res, output int lat);
    lat = 0;
    do begin @(negedge clk); lat++; regRead(2'd3, res); end
    while (res[31] && lat < 5000);
  endtask

  task automatic userReq(input bit wr, input logic [4:0] phy, input logic [4:0] ri,
                         input logic [15:0] d, output logic [31:0] res, output int lat);
    regWrite(2'd3, userWord(wr, phy, ri, d));
    waitGo(res, lat);
  endtask

  function automatic logic [4:0] pickPresent();
    logic [4:0] p;
    do p = 5'($urandom); while (!present[p]);
    return p;
  endfunction

  task automatic measurePeriod(input int exp, input string tag);
    longint prev;
    int eq, lo;
    eq = 0; lo = 0;
    repeat (70) @(posedge mdc);
    prev = cyc;
    for (int i = 0; i < 8; i++) begin
      @(posedge mdc);
      if (cyc - prev == exp) eq++;
      if (cyc - prev < exp) lo++;
      prev = cyc;
    end
    check(eq >= 6 && lo == 0, tag, 32'(eq), 32'd6);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      summary();
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [31:0] r, r2;
    int lat, maxLat, f0, m0;
    logic [4:0] p, ri, p2;
    logic [15:0] d;
    void'($urandom(32'd2024));
    present = $urandom; present[0] = 1'b1; present[5] = 1'b0; present[31] = 1'b1;
    linkMask = $urandom;
    for (int i = 0; i < 32; i++)
      for (int j = 0; j < 32; j++) begin
        mem[i][j] = 16'(i * 977 + j * 131 + 16'h3c5a);
        if (j == 1) mem[i][j][2] = linkMask[i];
      end

    repeat (4) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1 reset state
    regRead(2'd0, r); check(r == 32'h8000_000A, "R1 control", r, 32'h8000_000A);
    regRead(2'd1, r); check(r == 0, "R1 alive", r, 0);
    regRead(2'd2, r); check(r == 0, "R1 link", r, 0);
    regRead(2'd3, r); check(r == 0, "R1 user", r, 0);
    check(mdc == 0 && mdioOe == 0, "R1 bus idle", {30'd0, mdc, mdioOe}, 0);

    // R11 request while disabled stays pending
    regWrite(2'd3, userWord(1'b0, 5'd0, 5'd2, 16'd0));
    repeat (300) @(negedge clk);
    regRead(2'd3, r);
    check(r[31] == 1'b1, "R11 pending while disabled", r, 32'h8000_0000);
    check(frames == 0, "R11 no frame while disabled", 32'(frames), 0);

    // enable, divider 1: pending request goes first
    regWrite(2'd0, ctrlWord(1'b1, 16'd1));
    waitGo(r, lat);
    check(r[29] == 1'b1 && r[15:0] == mem[0][2], "R4 read after enable", r, {16'h2000, mem[0][2]});

    // R8/R9 one full sweep
    lat = 0;
    while (frames < 40 && lat < 20000) begin @(negedge clk); lat++; end
    regRead(2'd1, r); check(r == present, "R8 alive bitmap", r, present);
    regRead(2'd2, r); check(r == (present & linkMask), "R9 link bitmap", r, present & linkMask);
    check(orderErr == 0, "R8 ascending scan order", 32'(orderErr), 0);

    // R4 random reads while scanning, R10 latency
    maxLat = 0;
    for (int k = 0; k < 8; k++) begin
      p = pickPresent(); ri = 5'(2 + $urandom % 30);
      repeat ($urandom % 150) @(negedge clk);
      userReq(1'b0, p, ri, 16'h0, r, lat);
      if (lat > maxLat) maxLat = lat;
      check(r[31] == 0 && r[29] == 1 && r[15:0] == mem[p][ri] && r[20:16] == p && r[25:21] == ri,
            "R4 user read", r, {6'b001000, ri, p, mem[p][ri]});
    end

    // R5 absent PHY
    userReq(1'b0, 5'd5, 5'd3, 16'h0, r, lat);
    if (lat > maxLat) maxLat = lat;
    check(r[31] == 0 && r[29] == 0, "R5 no answer gives ACK 0", r, 32'h0);

    // R6 writes then read back
    for (int k = 0; k < 5; k++) begin
      p = pickPresent(); ri = 5'(2 + $urandom % 30); d = 16'($urandom);
      repeat ($urandom % 100) @(negedge clk);
      userReq(1'b1, p, ri, d, r, lat);
      if (lat > maxLat) maxLat = lat;
      check(r[31] == 0 && r[29] == 0, "R6 write ACK 0", r, {1'b0, 1'b1, 30'd0});
      userReq(1'b0, p, ri, 16'h0, r, lat);
      check(r[29] == 1 && r[15:0] == d, "R6 write reaches PHY", r, {16'h2000, d});
    end

    // R7 rewrite while GO pending
    p = pickPresent(); ri = 5'd7;
    do p2 = pickPresent(); while (p2 == p);
    d = mem[p2][5'd9];
    regWrite(2'd3, userWord(1'b0, p, ri, 16'h0));
    regWrite(2'd3, userWord(1'b1, p2, 5'd9, ~d));
    waitGo(r, lat);
    check(r[30] == 0 && r[20:16] == p && r[25:21] == ri && r[15:0] == mem[p][ri],
          "R7 original request kept", r, {6'b001000, ri, p, mem[p][ri]});
    userReq(1'b0, p2, 5'd9, 16'h0, r, lat);
    check(r[15:0] == d, "R7 ignored write not issued", r, {16'h2000, d});

    check(maxLat <= 2 * 128 + 16, "R10 user latency bound", 32'(maxLat), 32'(2 * 128 + 16));

    // R2 MDC period
    regWrite(2'd0, ctrlWord(1'b1, 16'd4));
    measurePeriod(5, "R2 period divider 4");
    regWrite(2'd0, ctrlWord(1'b1, 16'd0));
    measurePeriod(2, "R2 period divider 0");
    regWrite(2'd0, ctrlWord(1'b1, 16'd7));
    measurePeriod(8, "R2 period divider 7");

    // R11 disable, idle, quiet, resume
    regWrite(2'd0, ctrlWord(1'b0, 16'd1));
    lat = 0;
    do begin @(negedge clk); lat++; regRead(2'd0, r); end while (!r[31] && lat < 3000);
    check(r[31] == 1 && r[30] == 0, "R11 idle after disable", r, 32'h8000_0001);
    f0 = frames; m0 = mdcRises;
    repeat (1000) @(negedge clk);
    check(frames == f0 && mdcRises == m0 && mdc == 0, "R11 no activity while disabled", 32'(mdcRises - m0), 0);
    check(mdc == 0, "R2 MDC low when idle", {31'd0, mdc}, 0);
    regRead(2'd1, r2);
    check(r2 == present, "R11 alive held while disabled", r2, present);
    regWrite(2'd0, ctrlWord(1'b1, 16'd1));
    repeat (500) @(negedge clk);
    check(frames > f0, "R11 resumes on enable", 32'(frames - f0), 32'd1);

    check(contention == 0 && orderErr == 0, "R3 turnaround release and order", 32'(contention), 0);

    finished = 1;
    summary();
  end

endmodule